// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel character into a serial asynchronous frame on a single transmit line. A character comes in over a valid/ready handshake. The block then drives a low start bit, then the selected number of data bits with the least significant bit first, then a high stop period. The line sits high when no frame is being sent.

Two frame-format inputs set the character length and the stop period. A two-bit length code selects 5, 6, 7 or 8 data bits. A single stop flag selects either one stop bit or a longer stop period. When the length code asks for 5-bit characters, the longer stop period is one and a half bit times; for the other lengths it is two bit times. All timing comes from a baud tick that pulses once per sixteenth of a bit, which gives the half-bit resolution that the 1.5-bit stop needs.

The block copies the format inputs when it accepts a character, so changes to them during a frame take effect on the next frame. A busy flag is high for the whole frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx_line` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `busy` is 1 and `tx_line` is 0 for 16 baud ticks, which is the start bit.
- R3: `wlen_sel` selects the number of data bits N: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits 0 to N-1 of `in_data` follow the start bit, bit 0 first, and each is held for 16 ticks.
- R4: Bits of `in_data` at position N and above never appear on the line.
- R5: With `stop_sel` = 0, the line is high for exactly 16 ticks after the last data bit, and then `busy` falls.
- R6: With `stop_sel` = 1 and `wlen_sel` other than 00, the stop period is 32 ticks.
- R7: With `stop_sel` = 1 and `wlen_sel` = 00, the stop period is 24 ticks.
- R8: `wlen_sel` and `stop_sel` are sampled when the character is accepted. Changes during a frame do not affect it and apply to the next frame.
- R9: While `busy` is 1, `in_ready` is 0 and `in_valid` is ignored. `tx_line` and `busy` change only on cycles where `baud_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Transmitter idle, character can be taken |
| in_data | input | 8 | Character; only the low N bits are sent |
| wlen_sel | input | 2 | Character length code |
| stop_sel | input | 1 | 0: one stop bit; 1: longer stop period |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that `baud_tick` is never high on two cycles in a row, so that each tick is counted once. They also assume that `in_valid` is only sampled through the handshake. The check that the line and busy flag stay still between ticks depends on this. The bench produces one tick every third clock, driven on the falling edge. It drives the handshake and format inputs on falling edges only. It holds `in_valid` high through a whole frame to show that it is ignored, and it lowers `in_valid` before the transmitter could accept again.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [1:0] wlen_sel,
  input  logic       stop_sel,
  output logic       tx_line,
  output logic       busy
);
  localparam int CW = $clog2(2 * OSR);
  localparam logic [CW-1:0] LIM_ONE  = CW'(OSR - 1);
  localparam logic [CW-1:0] LIM_TWO  = CW'(2 * OSR - 1);
  localparam logic [CW-1:0] LIM_HALF = CW'(OSR + OSR / 2 - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] stop_lim;
  logic [2:0]    bit_idx;
  logic [2:0]    last_idx;
  logic [7:0]    shreg;
  logic          take;
  logic          bit_end;

  assign take     = in_valid && (st == S_IDLE);
  assign bit_end  = baud_tick && (cnt == ((st == S_STOP) ? stop_lim : LIM_ONE));
  assign in_ready = (st == S_IDLE);
  assign busy     = (st != S_IDLE);
  assign tx_line  = (st == S_START) ? 1'b0 : (st == S_DATA) ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      stop_lim <= LIM_ONE;
      bit_idx  <= '0;
      last_idx <= '0;
      shreg    <= '0;
    end else if (take) begin
      st       <= S_START;
      cnt      <= '0;
      bit_idx  <= '0;
      shreg    <= in_data;
      last_idx <= 3'd4 + {1'b0, wlen_sel};
      stop_lim <= !stop_sel ? LIM_ONE : (wlen_sel == 2'b00) ? LIM_HALF : LIM_TWO;
    end else if (st != S_IDLE && baud_tick) begin
      if (!bit_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            shreg <= shreg >> 1;
            if (bit_idx == last_idx) st <= S_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic in_valid,
  input logic in_ready,
  input logic tx_line,
  input logic busy
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line && in_ready); // R1
  AST_START_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy && !tx_line); // R2
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R9
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !baud_tick |=> $stable(tx_line) && busy); // R9
  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(baud_tick) && $past(tx_line)); // R5
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (.*);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       baud_tick = 0;
  logic       in_valid = 0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [1:0] wlen_sel = '0;
  logic       stop_sel = 0;
  logic       tx_line;
  logic       busy;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  uart_frame_tx u_dut (.*);

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      baud_tick = 1;
      @(negedge clk);
      baud_tick = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Sends one frame and checks the line waveform and stop length.
  // hold_valid: keep in_valid high during the frame (R9).
  // swap_fmt: change format inputs right after acceptance (R8).
  task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic sb,
                      input bit hold_valid, input bit swap_fmt, input string req);
    int n = 5 + wl;
    int stop_t = !sb ? 16 : (wl == 2'b00) ? 24 : 32;
    int i = 0;
    int bad_at = -1;
    int bad_act = 0;
    int bad_exp = 0;
    int ready_seen = 0;
    string len_req = !sb ? "R5" : (wl == 2'b00) ? "R7" : "R6";
    @(negedge clk);
    check("R1", in_ready, 1, "ready before frame");
    in_data = d; wlen_sel = wl; stop_sel = sb; in_valid = 1;
    @(negedge clk);
    if (!hold_valid) in_valid = 0;
    in_data = ~d;
    if (swap_fmt) begin wlen_sel = ~wl; stop_sel = ~sb; end
    check("R2", busy, 1, "busy after accept");
    while (busy && i < 500) begin
      if (in_ready) ready_seen++;
      if (baud_tick) begin
        int e;
        if (i < 16) e = 0;
        else if (i - 16 < 16 * n) e = d[(i - 16) / 16];
        else e = 1;
        if (tx_line !== e[0] && bad_at < 0) begin
          bad_at = i; bad_act = tx_line; bad_exp = e;
        end
        i++;
      end
      @(negedge clk);
    end
    in_valid = 0;
    if (bad_at >= 0)
      $display("FAIL %s waveform at tick %0d: actual=%0d expected=%0d", req, bad_at, bad_act, bad_exp);
    checks++;
    if (bad_at >= 0) errors++;
    check(len_req, i, 16 + 16 * n + stop_t, "frame length in ticks");
    check("R9", ready_seen, 0, "ready while busy");
    @(negedge clk);
    check("R9", busy, 0, "no second frame from held valid");
    check("R1", tx_line, 1, "line idle after frame");
  endtask

  task automatic test_reset;
    check("R1", tx_line, 1, "reset line");
    check("R1", busy, 0, "reset busy");
    check("R1", in_ready, 1, "reset ready");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    send(8'hA5, 2'b11, 1'b0, 0, 0, "R3");
    send(8'h13, 2'b00, 1'b1, 0, 0, "R7");
    send(8'h2C, 2'b01, 1'b1, 0, 0, "R6");
    send(8'h5A, 2'b10, 1'b0, 0, 0, "R3");
    send(8'hE0, 2'b00, 1'b0, 0, 0, "R4");
    send(8'hC1, 2'b01, 1'b0, 0, 0, "R4");
    send(8'h96, 2'b11, 1'b1, 0, 1, "R8");
    send(8'h0B, 2'b00, 1'b0, 0, 0, "R8");
    send(8'h3C, 2'b10, 1'b1, 1, 0, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule